// File: doc/BRIEF.md
# Predicated Vector Element-Step Sequencer

This block sits between instruction decode and issue. It takes one decoded vector operation and expands it into a series of per-element micro-operations. Element positions run upward from 0 towards the vector length. Two independent step counters, one for sources and one for destinations, each pass over the clear bits of their own predicate mask. This gives gather/scatter-style pairing of source and destination elements. Each micro-operation carries the 7-bit source and destination register numbers, a zero-write flag and a per-element condition-field index.

The pair of step counters forms a sub-program-counter word, visible on `state_o`. The sequencer never runs as a blocking loop: every element is a separate issue event, held until issue accepts it. A trap can stop the sequence between any two elements. When it does, the step word is copied into a shadow register, and a later start with the resume flag set picks up at the same element.

Top module: `elem_step_seq`

## Requirements
- R1: `start_i` is taken only while `busy_o` is low and `trap_i` is low; `busy_o` is high from the next cycle on. A `start_i` that arrives while busy is ignored.
- R2: While an element is offered and `issue_ready_i` is low, the same micro-operation and `state_o` are held. A step advances only on a cycle with `uop_valid_o`, `issue_ready_i` high and `trap_i` low.
- R3: A vector operand's register number is its base plus the element index, modulo 128 (7 bits). A scalar operand always gives its base.
- R4: The source step issues only the set source-mask bits, and the destination step only the set destination-mask bits, each in ascending order and below VL. An all-ones mask issues every element. `state_o` is {dststep, srcstep}, each IW = clog2(MAXVL+1) bits, with srcstep in the low bits; after an element is accepted, each advanced step holds the index it issued plus one.
- R5: When `mask_sel_i` is 0, the integer-register masks are used; when it is 1, the condition-register masks are used. The choice is captured at start.
- R6: When zeroing is on, destination elements whose mask bit is clear are not skipped. They are issued with `uop_zero_o`=1, and the source step does not advance on that element. When zeroing is off, `uop_zero_o` stays 0.
- R7: `uop_crf_we_o` equals the captured `rc_i` on each issued element, and `uop_crf_o` equals that element's destination index.
- R8: `done_o` pulses for one cycle, with `uop_valid_o` low, in the first active cycle where either step has no set mask bit left below VL. On the next cycle `busy_o` is low and `state_o` is 0.
- R9: If VL is 0, no element is issued and `done_o` is high in the cycle right after the start.
- R10: `trap_i` copies `state_o` into `saved_o`, with no element accepted in that cycle. The operation is dropped, so `busy_o` is low and `state_o` is 0 on the next cycle.
- R11: A start with `resume_i`=1 loads both steps from `saved_o`, and the sequence goes on at the element where the trap stopped it.
- R12: After reset, `busy_o`, `uop_valid_o`, `done_o`, `state_o` and `saved_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Decoded vector operation present |
| resume_i | input | 1 | Start from the saved step word instead of 0 |
| vl_i | input | IW | Vector length, 0 to MAXVL |
| src_base_i | input | 7 | Source base register number |
| dst_base_i | input | 7 | Destination base register number |
| src_vec_i | input | 1 | Source operand is a vector |
| dst_vec_i | input | 1 | Destination operand is a vector |
| mask_sel_i | input | 1 | 0: integer masks, 1: condition-register masks |
| src_mask_int_i | input | MAXVL | Source mask from an integer register |
| src_mask_cr_i | input | MAXVL | Source mask from condition bits |
| dst_mask_int_i | input | MAXVL | Destination mask from an integer register |
| dst_mask_cr_i | input | MAXVL | Destination mask from condition bits |
| zeroing_i | input | 1 | Masked-out destinations are written with zero |
| rc_i | input | 1 | Per-element condition update requested |
| issue_ready_i | input | 1 | Issue accepts the offered element |
| trap_i | input | 1 | Trap: save step word and drop the operation |
| busy_o | output | 1 | An operation is in progress |
| uop_valid_o | output | 1 | An element micro-operation is offered |
| uop_src_o | output | 7 | Source register number of the element |
| uop_dst_o | output | 7 | Destination register number of the element |
| uop_zero_o | output | 1 | Element is a zero write |
| uop_crf_o | output | IW | Condition field index of the element |
| uop_crf_we_o | output | 1 | Element updates its condition field |
| done_o | output | 1 | Operation complete pulse |
| state_o | output | 2*IW | Live step word {dststep, srcstep} |
| saved_o | output | 2*IW | Step word saved at the last trap |

## Verification
All outputs come combinationally from the registered step word. So a start shows its first element in the cycle after the start edge, an accepted element is followed by the next one on the following cycle, `done_o` comes one cycle after the last acceptance (for VL 0, one cycle after start), and `saved_o` and a cleared `busy_o` show one cycle after the trap edge. The bench changes its inputs on the falling edge and compares every output 1 ns later against a behavioural model. The model then advances exactly once per clock with the same inputs, so each expected value is tied to the cycle in which the design's registers can have changed. Directed checks cover the VL-0 pulse, a start while busy, mask bits above VL, register-number wrap, zeroing, and a trap followed by resume.

// File: rtl/elem_step_pkg.sv
package elem_step_pkg;
    localparam int REG_W = 7;

    typedef enum logic {
        MASK_FROM_INT = 1'b0,
        MASK_FROM_CR  = 1'b1
    } mask_src_e;
endpackage

// File: rtl/elem_step_scan.sv
// Finds the lowest set mask bit at or above a start position and below a limit.
module elem_step_scan #(
    parameter int NB = 16,
    parameter int IW = 5
) (
    input  logic [NB-1:0] mask_i,
    input  logic [IW-1:0] from_i,
    input  logic [IW-1:0] lim_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // descending walk leaves the lowest qualifying position
        for (int i = NB - 1; i >= 0; i--) begin
            if (mask_i[i] && (IW'(i) >= from_i) && (IW'(i) < lim_i)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/elem_step_regnum.sv
// Per-element register number: base plus index for vectors, base for scalars.
module elem_step_regnum #(
    parameter int IW = 5
) (
    input  logic [elem_step_pkg::REG_W-1:0] base_i,
    input  logic                            vec_i,
    input  logic [IW-1:0]                   idx_i,
    output logic [elem_step_pkg::REG_W-1:0] reg_o
);
    import elem_step_pkg::*;
    logic [REG_W-1:0] offs;

    always_comb begin
        offs  = vec_i ? REG_W'(idx_i) : '0;
        reg_o = base_i + offs;
    end
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq #(
    parameter int MAXVL = 16,
    localparam int IW = $clog2(MAXVL + 1),
    localparam int SW = 2 * IW
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            start_i,
    input  logic                            resume_i,
    input  logic [IW-1:0]                   vl_i,
    input  logic [elem_step_pkg::REG_W-1:0] src_base_i,
    input  logic [elem_step_pkg::REG_W-1:0] dst_base_i,
    input  logic                            src_vec_i,
    input  logic                            dst_vec_i,
    input  logic                            mask_sel_i,
    input  logic [MAXVL-1:0]                src_mask_int_i,
    input  logic [MAXVL-1:0]                src_mask_cr_i,
    input  logic [MAXVL-1:0]                dst_mask_int_i,
    input  logic [MAXVL-1:0]                dst_mask_cr_i,
    input  logic                            zeroing_i,
    input  logic                            rc_i,
    input  logic                            issue_ready_i,
    input  logic                            trap_i,
    output logic                            busy_o,
    output logic                            uop_valid_o,
    output logic [elem_step_pkg::REG_W-1:0] uop_src_o,
    output logic [elem_step_pkg::REG_W-1:0] uop_dst_o,
    output logic                            uop_zero_o,
    output logic [IW-1:0]                   uop_crf_o,
    output logic                            uop_crf_we_o,
    output logic                            done_o,
    output logic [SW-1:0]                   state_o,
    output logic [SW-1:0]                   saved_o
);
    import elem_step_pkg::*;

    typedef struct packed {
        logic             active;
        logic [IW-1:0]    sstep;
        logic [IW-1:0]    dstep;
        logic [IW-1:0]    vl;
        logic [REG_W-1:0] sbase;
        logic [REG_W-1:0] dbase;
        logic             svec;
        logic             dvec;
        logic             zero;
        logic             rc;
        logic [MAXVL-1:0] smask;
        logic [MAXVL-1:0] dmask;
        logic [SW-1:0]    shadow;
    } seq_state_t;

    seq_state_t q, d;

    logic             s_found, d_found;
    logic [IW-1:0]    s_idx, d_idx;
    logic [MAXVL-1:0] dscan_mask;
    logic             offer, dst_masked, accept, finish;
    logic [MAXVL-1:0] dmask_shift;

    // zeroing keeps every destination position live
    assign dscan_mask = q.zero ? '1 : q.dmask;

    elem_step_scan #(.NB(MAXVL), .IW(IW)) u_src_scan (
        .mask_i  (q.smask),
        .from_i  (q.sstep),
        .lim_i   (q.vl),
        .found_o (s_found),
        .idx_o   (s_idx)
    );

    elem_step_scan #(.NB(MAXVL), .IW(IW)) u_dst_scan (
        .mask_i  (dscan_mask),
        .from_i  (q.dstep),
        .lim_i   (q.vl),
        .found_o (d_found),
        .idx_o   (d_idx)
    );

    elem_step_regnum #(.IW(IW)) u_src_reg (
        .base_i (q.sbase),
        .vec_i  (q.svec),
        .idx_i  (s_idx),
        .reg_o  (uop_src_o)
    );

    elem_step_regnum #(.IW(IW)) u_dst_reg (
        .base_i (q.dbase),
        .vec_i  (q.dvec),
        .idx_i  (d_idx),
        .reg_o  (uop_dst_o)
    );

    always_comb begin
        d           = q;
        offer       = q.active & s_found & d_found;
        finish      = q.active & ~(s_found & d_found);
        dmask_shift = q.dmask >> d_idx;
        dst_masked  = q.zero & ~dmask_shift[0];
        accept      = offer & issue_ready_i & ~trap_i;

        if (trap_i) begin
            d.shadow = {q.dstep, q.sstep};
            d.active = 1'b0;
            d.sstep  = '0;
            d.dstep  = '0;
        end else if (!q.active) begin
            if (start_i) begin
                d.active = 1'b1;
                d.vl     = vl_i;
                d.sbase  = src_base_i;
                d.dbase  = dst_base_i;
                d.svec   = src_vec_i;
                d.dvec   = dst_vec_i;
                d.zero   = zeroing_i;
                d.rc     = rc_i;
                d.smask  = (mask_src_e'(mask_sel_i) == MASK_FROM_CR) ? src_mask_cr_i : src_mask_int_i;
                d.dmask  = (mask_src_e'(mask_sel_i) == MASK_FROM_CR) ? dst_mask_cr_i : dst_mask_int_i;
                d.sstep  = resume_i ? q.shadow[IW-1:0]  : '0;
                d.dstep  = resume_i ? q.shadow[SW-1:IW] : '0;
            end
        end else if (finish) begin
            d.active = 1'b0;
            d.sstep  = '0;
            d.dstep  = '0;
        end else if (accept) begin
            d.dstep = d_idx + 1'b1;
            if (!dst_masked) begin
                d.sstep = s_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = q.active;
    assign uop_valid_o  = offer;
    assign uop_zero_o   = offer & dst_masked;
    assign uop_crf_o    = d_idx;
    assign uop_crf_we_o = offer & q.rc;
    assign done_o       = finish;
    assign state_o      = {q.dstep, q.sstep};
    assign saved_o      = q.shadow;
endmodule

// File: rtl/elem_step_seq_chk.sv
module elem_step_seq_chk #(
    parameter int MAXVL = 16,
    localparam int IW = $clog2(MAXVL + 1),
    localparam int SW = 2 * IW
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          issue_ready_i,
    input logic          trap_i,
    input logic          busy_o,
    input logic          uop_valid_o,
    input logic          uop_zero_o,
    input logic          done_o,
    input logic [SW-1:0] state_o,
    input logic [SW-1:0] saved_o
);
    a_r1_start_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o && !trap_i |=> busy_o);

    a_r2_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uop_valid_o && !issue_ready_i && !trap_i |=> uop_valid_o && $stable(state_o));

    a_r2_offer_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uop_valid_o |-> busy_o);

    a_r6_zero_in_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uop_zero_o |-> uop_valid_o);

    a_r8_done_no_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !uop_valid_o);

    a_r8_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !trap_i |=> !busy_o && state_o == '0);

    a_r10_trap_saves: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> !busy_o && saved_o == $past(state_o));
endmodule

bind elem_step_seq elem_step_seq_chk #(.MAXVL(MAXVL)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .issue_ready_i (issue_ready_i),
    .trap_i        (trap_i),
    .busy_o        (busy_o),
    .uop_valid_o   (uop_valid_o),
    .uop_zero_o    (uop_zero_o),
    .done_o        (done_o),
    .state_o       (state_o),
    .saved_o       (saved_o)
);

// File: tb/elem_step_seq_bench.sv
`timescale 1ns/1ps
module elem_step_seq_bench;
    localparam int NV = 16;
    localparam int IW = $clog2(NV + 1);
    localparam int SW = 2 * IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start, resume, sv, dv, msel, zer, rc, ready, trap;
    logic [IW-1:0] vl;
    logic [6:0]    sb, db;
    logic [NV-1:0] smi, smc, dmi, dmc;
    logic          busy, valid, zout, crfwe, done;
    logic [6:0]    usrc, udst;
    logic [IW-1:0] crf;
    logic [SW-1:0] state, saved;

    elem_step_seq #(.MAXVL(NV)) u_elem_step_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .resume_i(resume), .vl_i(vl),
        .src_base_i(sb), .dst_base_i(db), .src_vec_i(sv), .dst_vec_i(dv),
        .mask_sel_i(msel), .src_mask_int_i(smi), .src_mask_cr_i(smc),
        .dst_mask_int_i(dmi), .dst_mask_cr_i(dmc), .zeroing_i(zer), .rc_i(rc),
        .issue_ready_i(ready), .trap_i(trap), .busy_o(busy), .uop_valid_o(valid),
        .uop_src_o(usrc), .uop_dst_o(udst), .uop_zero_o(zout), .uop_crf_o(crf),
        .uop_crf_we_o(crfwe), .done_o(done), .state_o(state), .saved_o(saved)
    );

    int checks = 0;
    int errors = 0;
    string ctx = "";
    int cycles = 0;

    // behavioural model
    int m_act = 0, m_ss = 0, m_ds = 0, m_vl = 0, m_sb = 0, m_db = 0;
    int m_sv = 0, m_dv = 0, m_z = 0, m_rc = 0, m_hs = 0, m_hd = 0;
    logic [NV-1:0] m_sm = '0, m_dm = '0;

    function automatic int find_set(logic [NV-1:0] m, int from, int lim);
        for (int i = from; i < lim; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s]: got %0d expected %0d at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    // called right after a falling edge with inputs already set
    task automatic tick();
        int si, di, go, zm;
        #1;
        si = m_act ? find_set(m_sm, m_ss, m_vl) : -1;
        if (m_z != 0) di = (m_ds < m_vl) ? m_ds : -1;
        else          di = m_act ? find_set(m_dm, m_ds, m_vl) : -1;
        go = (m_act != 0 && si >= 0 && di >= 0) ? 1 : 0;
        zm = (go != 0 && m_z != 0 && m_dm[di] == 1'b0) ? 1 : 0;
        chk("R1 busy", int'(busy), m_act);
        chk("R2 valid", int'(valid), go);
        chk("R8 done", int'(done), (m_act != 0 && go == 0) ? 1 : 0);
        chk("R4 state", int'(state), (m_ds << IW) | m_ss);
        chk("R10 saved", int'(saved), (m_hd << IW) | m_hs);
        if (go != 0) begin
            chk("R3 src", int'(usrc), (m_sb + (m_sv != 0 ? si : 0)) % 128);
            chk("R3 dst", int'(udst), (m_db + (m_dv != 0 ? di : 0)) % 128);
            chk("R6 zero", int'(zout), zm);
            chk("R7 crf", int'(crf), di);
            chk("R7 crf_we", int'(crfwe), m_rc);
        end
        if (trap) begin
            m_hs = m_ss; m_hd = m_ds; m_act = 0; m_ss = 0; m_ds = 0;
        end else if (m_act == 0) begin
            if (start) begin
                m_act = 1; m_vl = int'(vl); m_sb = int'(sb); m_db = int'(db);
                m_sv = int'(sv); m_dv = int'(dv); m_z = int'(zer); m_rc = int'(rc);
                m_sm = msel ? smc : smi;
                m_dm = msel ? dmc : dmi;
                m_ss = resume ? m_hs : 0;
                m_ds = resume ? m_hd : 0;
            end
        end else if (go == 0) begin
            m_act = 0; m_ss = 0; m_ds = 0;
        end else if (ready) begin
            m_ds = di + 1;
            if (zm == 0) m_ss = si + 1;
        end
        @(negedge clk);
    endtask

    task automatic set_op(int l, int s_b, int d_b, bit s_v, bit d_v, bit sel,
                          logic [NV-1:0] s_i, logic [NV-1:0] s_c,
                          logic [NV-1:0] d_i, logic [NV-1:0] d_c, bit z, bit r);
        vl = IW'(l); sb = 7'(s_b); db = 7'(d_b); sv = s_v; dv = d_v; msel = sel;
        smi = s_i; smc = s_c; dmi = d_i; dmc = d_c; zer = z; rc = r;
    endtask

    task automatic launch(bit res);
        start = 1'b1; resume = res; ready = 1'b1;
        tick();
        start = 1'b0; resume = 1'b0;
    endtask

    // mode 0: always ready; mode 1: ready two cycles of three
    task automatic run_idle(int mode);
        for (int k = 0; k < 80 && (m_act != 0); k++) begin
            ready = (mode == 0) ? 1'b1 : ((k % 3) != 2);
            tick();
        end
        ready = 1'b1;
        tick();
    endtask

    initial begin
        start = 0; resume = 0; ready = 1; trap = 0;
        set_op(0, 0, 0, 0, 0, 0, '0, '0, '0, '0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        ctx = "R12 reset state";
        tick();
        chk("R12 valid", int'(valid), 0);

        ctx = "R4 all-ones mask";
        set_op(5, 10, 20, 1, 1, 0, '1, '0, '1, '0, 0, 0);
        launch(0); run_idle(0);

        ctx = "R4 twin masks, scalar source";
        set_op(12, 3, 40, 0, 1, 0, 16'h0A5C, 16'h0000, 16'h3F01, 16'h0000, 0, 0);
        launch(0); run_idle(1);

        ctx = "R5 condition-register masks";
        set_op(16, 8, 64, 1, 1, 1, 16'h0001, 16'hC3A5, 16'h0001, 16'h5AF0, 0, 1);
        launch(0); run_idle(1);

        ctx = "R5 integer masks";
        set_op(16, 8, 64, 1, 1, 0, 16'h9009, 16'hFFFF, 16'h00FF, 16'hFFFF, 0, 0);
        launch(0); run_idle(0);

        ctx = "R6 R7 zeroing with rc";
        set_op(10, 0, 30, 1, 1, 0, 16'hFFFF, '0, 16'h00F0, '0, 1, 1);
        launch(0); run_idle(1);

        ctx = "R6 zeroing, sparse source";
        set_op(10, 50, 60, 1, 1, 0, 16'h0111, '0, 16'h0205, '0, 1, 0);
        launch(0); run_idle(0);

        ctx = "R3 register wrap";
        set_op(16, 125, 120, 1, 1, 0, '1, '0, '1, '0, 0, 0);
        launch(0); run_idle(0);

        ctx = "R8 mask bits above VL";
        set_op(8, 1, 2, 1, 1, 0, '1, '0, 16'hFF00, '0, 0, 0);
        launch(0);
        chk("R8 done", int'(done), 1);
        run_idle(0);

        ctx = "R9 zero length";
        set_op(0, 1, 2, 1, 1, 0, '1, '0, '1, '0, 0, 0);
        launch(0);
        #1 chk("R9 done", int'(done), 1);
        chk("R9 valid", int'(valid), 0);
        run_idle(0);

        ctx = "R1 start while busy";
        set_op(6, 4, 14, 1, 1, 0, '1, '0, '1, '0, 0, 0);
        launch(0);
        tick();
        set_op(3, 90, 91, 0, 0, 1, 16'h0004, 16'h0004, 16'h0004, 16'h0004, 1, 1);
        start = 1'b1; tick(); start = 1'b0;
        chk("R1 busy", int'(busy), 1);
        run_idle(0);

        ctx = "R10 R11 trap and resume";
        set_op(9, 16, 32, 1, 1, 0, 16'h01B6, '0, 16'h01DB, '0, 0, 1);
        launch(0);
        tick(); tick();
        trap = 1'b1; ready = 1'b1; tick(); trap = 1'b0;
        chk("R10 busy", int'(busy), 0);
        tick(); tick();
        ctx = "R11 resume";
        launch(1);
        chk("R11 state", int'(state), int'(saved));
        run_idle(1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog [%s]: got %0d expected %0d", ctx, cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule